// File: doc/BRIEF.md
# Prescaled Interval-Timer PWM Channel

This block is one timer channel that turns a programmed interval and a programmed match value into a pulse-width-modulated output. An up-counter runs from zero to the interval value and wraps. The output is in its active phase while the count is below the match value. A power-of-two prescaler can slow the count rate. A polarity bit selects whether the active phase drives the pin high or low.

Software programs the channel through a small register port. It first halts the channel, then writes the interval, match and clock-control registers, then clears the halt bit. Halting freezes the channel at once, even part way through a period, and parks the output at the inactive level. Every register write restarts the waveform from the start of a period, so a new setting never mixes with a period that was already running. Each register reads back what was last written, so the complete setting can be recovered.

Top module: `pwm_tmr_chan`

## Requirements
- R1: After a synchronous active-high reset, every register field is zero except the halt bit, which is one. The channel is therefore halted with inverted polarity, and `pwm_out` is 1.
- R2: When clock-control bit 0 (prescale enable, register address 3) is set, the counter advances once every 2^(psv+1) clocks, where psv is clock-control bits 4:1. A psv of 15 gives one advance every 65536 clocks.
- R3: When prescale enable is clear, the counter advances on every clock.
- R4: The counter runs 0, 1, ..., interval (register address 0) and then returns to 0, so one period lasts (interval+1) count steps. The active phase lasts while the count is below the match value (register address 1).
- R5: Counter-control bit 1 (register address 2) selects polarity. When it is 1, the output is high in the active phase and low otherwise. When it is 0, the output is inverted.
- R6: A match value of 0 keeps the output at the inactive level for good. A match value greater than the interval keeps it at the active level for good.
- R7: While counter-control bit 0 (halt) is set, the counter stays at zero and does not finish the current period. The output sits at the inactive level, which is the inverse of the polarity bit. This takes effect in the cycle right after the halting write.
- R8: Any register write returns the count and the prescale phase to zero at the same clock edge, and the write wins over a counter advance at that edge. Clearing the halt bit therefore starts a fresh period at count zero.
- R9: Reading address 0 returns the interval, address 1 the match value, address 2 {polarity, halt} in bits 1:0, and address 3 {psv, enable} in bits 4:0. All unused bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for reg_addr (combinational) |
| pwm_out | output | 1 | PWM waveform |

## Verification
A register write and a counter advance, or a prescaler tick, can fall on the same clock edge. The bench provokes this by writing a new match value while the channel runs unprescaled, so every edge is also a counting edge. The write must win. The bench judges this by comparing each following cycle of `pwm_out` with a waveform computed from count zero, which a continued count would break at once. Halting part way through a period is judged the same way after the restart.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    // Width of the prescale exponent field
    localparam int PSV_W = 4;

    // Register addresses
    localparam logic [1:0] A_INTV  = 2'd0;
    localparam logic [1:0] A_MATCH = 2'd1;
    localparam logic [1:0] A_CTL   = 2'd2;
    localparam logic [1:0] A_CLK   = 2'd3;

    // Counter control: bit 1 polarity (1 = active high), bit 0 halt
    typedef struct packed {
        logic pol;
        logic halt;
    } ctl_t;

    // Clock control: bits PSV_W:1 exponent, bit 0 prescale enable
    typedef struct packed {
        logic [PSV_W-1:0] psv;
        logic             pre_en;
    } clk_ctl_t;

    localparam int CTL_W = $bits(ctl_t);
    localparam int CLK_W = $bits(clk_ctl_t);

endpackage

// File: rtl/pwm_tmr_prescale.sv
module pwm_tmr_prescale
    import pwm_tmr_pkg::*;
#(
    parameter int PRE_W = 1 << PSV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             pre_en,
    input  logic [PSV_W-1:0] psv,
    output logic             tick,
    output logic [PRE_W-1:0] pre_cnt,
    output logic [PRE_W-1:0] pre_lim
);
    localparam logic [PSV_W-1:0] PSV_TOP = PSV_W'(PRE_W - 1);

    logic [PRE_W-1:0] cnt_d, cnt_q;
    logic             at_lim;

    // Terminal count is 2^(psv+1)-1, formed without an overflowing shift
    assign pre_lim = {PRE_W{1'b1}} >> (PSV_TOP - psv);
    assign at_lim  = (cnt_q == pre_lim);

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (!pre_en) begin
            cnt_d = '0;
            tick  = 1'b1;
        end else begin
            tick  = at_lim;
            cnt_d = at_lim ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign pre_cnt = cnt_q;

endmodule

// File: rtl/pwm_tmr_count.sv
module pwm_tmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] intv,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (tick) cnt_d = (cnt_q == intv) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/pwm_tmr_wave.sv
module pwm_tmr_wave #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] mtch,
    input  logic             halt,
    input  logic             pol,
    output logic             wave
);
    logic active;

    always_comb begin
        active = !halt && (cnt < mtch);
        wave   = active ? pol : !pol;
    end

endmodule

// File: rtl/pwm_tmr_chan.sv
module pwm_tmr_chan
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16   // at least CLK_W bits wide
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             pwm_out
);
    localparam int PRE_W = 1 << PSV_W;

    typedef struct packed {
        logic [CNT_W-1:0] intv;
        logic [CNT_W-1:0] mtch;
        ctl_t             ctl;
        clk_ctl_t         ck;
    } regs_t;

    localparam regs_t REGS_RST = '{
        intv: '0, mtch: '0, ctl: '{pol: 1'b0, halt: 1'b1}, ck: '0
    };

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (reg_we) begin
            unique case (reg_addr)
                A_INTV:  regs_d.intv = reg_wdata;
                A_MATCH: regs_d.mtch = reg_wdata;
                A_CTL:   regs_d.ctl  = ctl_t'(reg_wdata[CTL_W-1:0]);
                A_CLK:   regs_d.ck   = clk_ctl_t'(reg_wdata[CLK_W-1:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= REGS_RST;
        else     regs_q <= regs_d;
    end

    always_comb begin
        unique case (reg_addr)
            A_INTV:  reg_rdata = regs_q.intv;
            A_MATCH: reg_rdata = regs_q.mtch;
            A_CTL:   reg_rdata = CNT_W'(regs_q.ctl);
            default: reg_rdata = CNT_W'(regs_q.ck);
        endcase
    end

    // Halting or any write keeps the counting chain at its start
    logic             restart;
    logic             tick;
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_lim;
    logic [CNT_W-1:0] cnt;
    logic             halt, pol, pre_en;

    assign halt    = regs_q.ctl.halt;
    assign pol     = regs_q.ctl.pol;
    assign pre_en  = regs_q.ck.pre_en;
    assign restart = halt | reg_we;

    pwm_tmr_prescale #(.PRE_W(PRE_W)) i_pre (
        .clk     (clk),
        .rst     (rst),
        .clr     (restart),
        .pre_en  (pre_en),
        .psv     (regs_q.ck.psv),
        .tick    (tick),
        .pre_cnt (pre_cnt),
        .pre_lim (pre_lim)
    );

    pwm_tmr_count #(.CNT_W(CNT_W)) i_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (restart),
        .tick (tick),
        .intv (regs_q.intv),
        .cnt  (cnt)
    );

    pwm_tmr_wave #(.CNT_W(CNT_W)) i_wave (
        .cnt  (cnt),
        .mtch (regs_q.mtch),
        .halt (halt),
        .pol  (pol),
        .wave (pwm_out)
    );

endmodule

// File: rtl/pwm_tmr_chan_chk.sv
module pwm_tmr_chan_chk #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_we,
    input logic             pwm_out,
    input logic             halt,
    input logic             pol,
    input logic             pre_en,
    input logic [PRE_W-1:0] pre_cnt,
    input logic [PRE_W-1:0] pre_lim,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] intv,
    input logic [CNT_W-1:0] mtch
);

    p_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt <= intv));

    p_every_clk_r3: assert property (@(posedge clk) disable iff (rst)
        (!halt && !pre_en && !reg_we && cnt < intv) |=> (cnt == $past(cnt) + 1'b1));

    p_pre_stall_r2: assert property (@(posedge clk) disable iff (rst)
        (!halt && pre_en && !reg_we && pre_cnt != pre_lim) |=> $stable(cnt));

    p_halt_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (halt && !reg_we) |=> (cnt == '0));

    p_idle_level_r7: assert property (@(posedge clk) disable iff (rst)
        halt |-> (pwm_out == !pol));

    p_zero_match_r6: assert property (@(posedge clk) disable iff (rst)
        (mtch == '0) |-> (pwm_out == !pol));

    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> (cnt == '0 && pre_cnt == '0));

endmodule

bind pwm_tmr_chan pwm_tmr_chan_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .reg_we  (reg_we),
    .pwm_out (pwm_out),
    .halt    (halt),
    .pol     (pol),
    .pre_en  (pre_en),
    .pre_cnt (pre_cnt),
    .pre_lim (pre_lim),
    .cnt     (cnt),
    .intv    (regs_q.intv),
    .mtch    (regs_q.mtch)
);

// File: tb/test_pwm_tmr_chan.sv
module test_pwm_tmr_chan;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_we = 1'b0;
    logic [1:0]       reg_addr = 2'd0;
    logic [CNT_W-1:0] reg_wdata = '0;
    logic [CNT_W-1:0] reg_rdata;
    logic             pwm_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pwm_tmr_chan #(.CNT_W(CNT_W)) i_pwm_tmr_chan (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Write one register; returns at the negedge after the write edge
    task automatic wr(logic [1:0] a, int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = CNT_W'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(string tag, logic [1:0] a, int exp);
        reg_addr = a;
        #1;
        chk(tag, int'(reg_rdata), exp);
    endtask

    // Halt, program, then release; returns at step k = 0 of a fresh period
    task automatic cfg(int iv, int m, bit pol, bit pe, int psv);
        wr(2'd2, {pol, 1'b1});
        wr(2'd0, iv);
        wr(2'd1, m);
        wr(2'd3, (psv << 1) | int'(pe));
        wr(2'd2, {pol, 1'b0});
    endtask

    // Expected output at clock step k after a restart
    function automatic bit model(int k, int iv, int m, bit pol, int div);
        bit act;
        act = ((k / div) % (iv + 1)) < m;
        return pol ? act : !act;
    endfunction

    task automatic run_chk(string tag, int iv, int m, bit pol, int div, int n);
        for (int k = 0; k < n; k++) begin
            chk(tag, int'(pwm_out), int'(model(k, iv, m, pol, div)));
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1 output after reset", int'(pwm_out), 1);
        rd("R1 ctl after reset", 2'd2, 1);
        rd("R1 interval after reset", 2'd0, 0);
        rd("R1 clock ctl after reset", 2'd3, 0);
    endtask

    task automatic t_basic();
        cfg(4, 2, 1'b1, 1'b0, 0);
        run_chk("R3 R4 unprescaled normal", 4, 2, 1'b1, 1, 15);
        cfg(4, 2, 1'b0, 1'b0, 0);
        run_chk("R5 inverted polarity", 4, 2, 1'b0, 1, 15);
    endtask

    task automatic t_prescale();
        cfg(2, 1, 1'b1, 1'b1, 1);
        run_chk("R2 prescale psv=1 div4", 2, 1, 1'b1, 4, 30);
        cfg(3, 2, 1'b0, 1'b1, 0);
        run_chk("R2 prescale psv=0 div2", 3, 2, 1'b0, 2, 20);
    endtask

    task automatic t_extremes();
        cfg(3, 0, 1'b1, 1'b0, 0);
        run_chk("R6 match zero inactive", 3, 0, 1'b1, 1, 10);
        cfg(3, 4, 1'b1, 1'b0, 0);
        run_chk("R6 match above interval active", 3, 4, 1'b1, 1, 10);
        cfg(3, 4, 1'b0, 1'b0, 0);
        run_chk("R6 match above interval inverted", 3, 4, 1'b0, 1, 10);
    endtask

    task automatic t_halt();
        cfg(9, 5, 1'b1, 1'b0, 0);
        run_chk("R4 before halt", 9, 5, 1'b1, 1, 3);
        wr(2'd2, 2'b11);
        for (int i = 0; i < 4; i++) begin
            chk("R7 halted low", int'(pwm_out), 0);
            @(negedge clk);
        end
        wr(2'd2, 2'b10);
        run_chk("R8 fresh period after release", 9, 5, 1'b1, 1, 12);
        wr(2'd2, 2'b01);
        chk("R7 halted inverted high", int'(pwm_out), 1);
    endtask

    task automatic t_collide();
        cfg(4, 2, 1'b1, 1'b0, 0);
        run_chk("R4 before write", 4, 2, 1'b1, 1, 2);
        wr(2'd1, 3);
        run_chk("R8 write beats advance", 4, 3, 1'b1, 1, 12);
    endtask

    task automatic t_readback();
        wr(2'd0, 16'hABCD);
        wr(2'd1, 16'h1234);
        wr(2'd2, 16'hFFFF);
        wr(2'd3, 16'hFFFF);
        rd("R9 interval", 2'd0, 16'hABCD);
        rd("R9 match", 2'd1, 16'h1234);
        rd("R9 ctl", 2'd2, 3);
        rd("R9 clock ctl", 2'd3, 16'h1F);
    endtask

    task automatic t_psv_max();
        cfg(1, 1, 1'b1, 1'b1, 15);
        chk("R2 psv15 start active", int'(pwm_out), 1);
        repeat (65535) @(negedge clk);
        chk("R2 psv15 still active", int'(pwm_out), 1);
        @(negedge clk);
        chk("R2 psv15 advanced at 65536", int'(pwm_out), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_prescale();
        t_extremes();
        t_halt();
        t_collide();
        t_readback();
        t_psv_max();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule